// File: doc/BRIEF.md
# Soft-Start and Soft-Stop Reference Sequencer

This block produces the digital reference code that a switching regulator's error amplifier follows. After the enable rises, it raises the code from zero to full scale one step at a time. After the enable falls, it lowers the code one step at a time. Each step lasts a fixed number of switching cycles. A one-clock tick marks each switching cycle and sets the pace. The block counts these ticks, so the output voltage ramps smoothly in both directions instead of jumping.

The block also owns the enable for both gate drivers. The drivers switch for the whole soft-stop and are released only when the code has returned to zero. A supply-good flag overrides everything. When supply is lost, the drivers stop and the code clears on the next clock. When supply comes back with the enable still high, a new ramp starts from zero.

Top module: `softramp_seq`

## Requirements
- R1: While reset is asserted, `ref_code` is 0, and `drv_en`, `up_done` and `down_done` are all low.
- R2: With `supply_ok` high and `en` low, the block stays off: ticks leave `ref_code` at 0 and `drv_en` low. If `en` is high and `supply_ok` is high, `drv_en` rises on the next clock and `ref_code` stays at 0.
- R3: The reference code changes only on a clock edge that samples a tick, and only on the 32nd tick counted since the current step began. Between those edges the code holds its value.
- R4: During a ramp up, `ref_code` rises by exactly 1 per step. It reaches the full-scale code 64 after 2048 ticks, then stays at 64 while `en` stays high.
- R5: `up_done` is high for exactly one clock. That clock is the first one in which `ref_code` reads 64 after an increment.
- R6: After `en` falls in steady operation, `ref_code` falls by exactly 1 every 32 ticks. `drv_en` stays high for as long as the code is above 0.
- R7: When the downward ramp reaches 0, `drv_en` falls and `down_done` pulses high for one clock. Both happen on the same clock edge that sets the code to 0.
- R8: If `en` rises again during a downward ramp, the direction reverses from the current code, without dropping to 0. The step count restarts, so the next increment comes 32 ticks after the reversal.
- R9: If `en` falls during an upward ramp while the code is above 0, the block ramps down from the current code. The step count restarts, so the next decrement comes 32 ticks after the fall.
- R10: If `supply_ok` is low at a clock edge, then after that edge `ref_code` is 0 and `drv_en` is low, whatever `en` is. No done flag pulses. Ticks have no effect while `supply_ok` stays low.
- R11: When `supply_ok` returns high while `en` is high, `drv_en` rises on the next clock. A new ramp then starts from code 0, and the first increment comes after 32 ticks.
- R12: If `en` falls during an upward ramp while the code is still 0, the block turns off on the next clock. At that clock `drv_en` falls and `down_done` pulses for one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse per switching cycle |
| en | input | 1 | Active-high converter enable |
| supply_ok | input | 1 | High while supply is above the undervoltage threshold |
| ref_code | output | 7 | Reference code, 0 to 64, in 1/64 steps of full scale |
| drv_en | output | 1 | Enable for both gate drivers |
| up_done | output | 1 | One-clock pulse when the upward ramp reaches full scale |
| down_done | output | 1 | One-clock pulse when the downward ramp reaches zero |

## Verification
The most likely internal faults are a step counter that is off by one tick, or one that fails to restart on a reversal. Either fault shows at the ports within a single step, as a code change one tick early or late. The bench checks every step boundary of both full ramps, one tick before the edge and exactly at it, so such a fault shows up within 33 ticks. A wrong state transition shows up within one clock as a `drv_en` level or a done pulse out of place. The undervoltage override and the reversals each have their own check on the clock that follows the stimulus.

// File: rtl/softramp_pkg.sv
package softramp_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_UP   = 2'd1,
      ST_RUN  = 2'd2,
      ST_DOWN = 2'd3
   } ramp_state_t;
endpackage

// File: rtl/softramp_pacer.sv
// Counts switching-cycle ticks and flags the tick that closes a step.
module softramp_pacer #(
   parameter int unsigned TICKS_PER_STEP = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   output logic step
);
   generate
      if (TICKS_PER_STEP == 1) begin : g_direct
         assign step = run & tick;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(TICKS_PER_STEP);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_STEP - 1);
         logic [CNT_W-1:0] cnt;

         assign step = run & tick & (cnt == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (clear)
               cnt <= '0;
            else if (run && tick)
               cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/softramp_code.sv
// Holds the reference code; clears, steps up or steps down on request.
module softramp_code #(
   parameter int unsigned CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zero,
   input  logic              inc,
   input  logic              dec,
   output logic [CODE_W-1:0] code
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         code <= '0;
      else if (zero)
         code <= '0;
      else if (inc)
         code <= code + 1'b1;
      else if (dec)
         code <= code - 1'b1;
   end
endmodule

// File: rtl/softramp_fsm.sv
// Sequencing state machine with supply gating and done pulses.
module softramp_fsm
   import softramp_pkg::*;
#(
   parameter int unsigned CODE_MAX = 64,
   parameter int unsigned CODE_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              supply_ok,
   input  logic              step,
   input  logic [CODE_W-1:0] code,
   output logic              pace_run,
   output logic              pace_clear,
   output logic              code_zero,
   output logic              code_inc,
   output logic              code_dec,
   output logic              drv_en,
   output logic              up_done,
   output logic              down_done
);
   localparam logic [CODE_W-1:0] TOP     = CODE_W'(CODE_MAX);
   localparam logic [CODE_W-1:0] TOP_M1  = CODE_W'(CODE_MAX - 1);
   localparam logic [CODE_W-1:0] ONE     = CODE_W'(1);

   ramp_state_t state, state_nx;
   logic        up_done_nx, down_done_nx;

   always_comb begin
      state_nx = state;
      if (!supply_ok) begin
         state_nx = ST_OFF;
      end else begin
         unique case (state)
            ST_OFF:  if (en) state_nx = ST_UP;
            ST_UP: begin
               if (!en)
                  state_nx = (code == '0) ? ST_OFF : ST_DOWN;
               else if (step && code == TOP_M1)
                  state_nx = ST_RUN;
            end
            ST_RUN:  if (!en) state_nx = ST_DOWN;
            ST_DOWN: begin
               if (en)
                  state_nx = (code == TOP) ? ST_RUN : ST_UP;
               else if (step && code == ONE)
                  state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
         endcase
      end
   end

   assign pace_run   = (state == ST_UP) || (state == ST_DOWN);
   assign pace_clear = !supply_ok || (state_nx != state);
   assign code_zero  = !supply_ok;
   assign code_inc   = supply_ok && en  && (state == ST_UP)   && step;
   assign code_dec   = supply_ok && !en && (state == ST_DOWN) && step;

   assign up_done_nx   = code_inc && (code == TOP_M1);
   assign down_done_nx = (code_dec && (code == ONE)) ||
                         (supply_ok && !en && (state == ST_UP) && (code == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_OFF;
         up_done   <= 1'b0;
         down_done <= 1'b0;
      end else begin
         state     <= state_nx;
         up_done   <= up_done_nx;
         down_done <= down_done_nx;
      end
   end

   assign drv_en = (state != ST_OFF);
endmodule

// File: rtl/softramp_seq.sv
// Top: soft-start / soft-stop reference sequencer.
module softramp_seq #(
   parameter int unsigned CODE_MAX       = 64,
   parameter int unsigned TICKS_PER_STEP = 32,
   parameter int unsigned CODE_W         = $clog2(CODE_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              supply_ok,
   output logic [CODE_W-1:0] ref_code,
   output logic              drv_en,
   output logic              up_done,
   output logic              down_done
);
   generate
      if (CODE_MAX < 2) begin : g_bad_max
         $error("softramp_seq: CODE_MAX must be at least 2");
      end
      if (TICKS_PER_STEP < 1) begin : g_bad_tps
         $error("softramp_seq: TICKS_PER_STEP must be at least 1");
      end
      if (CODE_W < $clog2(CODE_MAX + 1)) begin : g_bad_w
         $error("softramp_seq: CODE_W too narrow for CODE_MAX");
      end
   endgenerate

   logic step, pace_run, pace_clear, code_zero, code_inc, code_dec;

   softramp_pacer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (pace_clear),
      .run   (pace_run),
      .tick  (tick),
      .step  (step)
   );

   softramp_fsm #(.CODE_MAX(CODE_MAX), .CODE_W(CODE_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .supply_ok  (supply_ok),
      .step       (step),
      .code       (ref_code),
      .pace_run   (pace_run),
      .pace_clear (pace_clear),
      .code_zero  (code_zero),
      .code_inc   (code_inc),
      .code_dec   (code_dec),
      .drv_en     (drv_en),
      .up_done    (up_done),
      .down_done  (down_done)
   );

   softramp_code #(.CODE_W(CODE_W)) u_code (
      .clk   (clk),
      .rst_n (rst_n),
      .zero  (code_zero),
      .inc   (code_inc),
      .dec   (code_dec),
      .code  (ref_code)
   );
endmodule

// File: rtl/softramp_seq_chk.sv
// Port-level properties of the sequencer, attached by bind.
module softramp_seq_chk #(
   parameter int unsigned CODE_MAX = 64,
   parameter int unsigned CODE_W   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              en,
   input logic              supply_ok,
   input logic [CODE_W-1:0] ref_code,
   input logic              drv_en,
   input logic              up_done,
   input logic              down_done
);
   // R3: a code change with supply present needs a tick at that edge
   p_code_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_code != $past(ref_code)) && $past(supply_ok) |-> $past(tick));

   // R4: with supply present the code moves by at most one
   p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_code != $past(ref_code)) && $past(supply_ok) |->
      (int'(ref_code) == int'($past(ref_code)) + 1) ||
      (int'(ref_code) + 1 == int'($past(ref_code))));

   // R4: never above full scale
   p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ref_code) <= int'(CODE_MAX));

   // R5: up pulse only at full scale, one clock wide
   p_up_done_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      up_done |-> int'(ref_code) == int'(CODE_MAX));
   p_up_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      up_done |=> !up_done);

   // R6: drivers are only off with a zero code
   p_drv_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |-> ref_code == '0);

   // R7: down pulse coincides with drivers falling at zero
   p_down_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      down_done |-> !drv_en && ref_code == '0 && $past(drv_en));
   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({up_done, down_done}));

   // R10: supply loss forces off on the next clock
   p_uv_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> ref_code == '0 && !drv_en && !down_done && !up_done);
endmodule

bind softramp_seq softramp_seq_chk #(.CODE_MAX(CODE_MAX), .CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .en        (en),
   .supply_ok (supply_ok),
   .ref_code  (ref_code),
   .drv_en    (drv_en),
   .up_done   (up_done),
   .down_done (down_done)
);

// File: tb/softramp_seq_bench.sv
module softramp_seq_bench;
   localparam int FULL = 64;
   localparam int TPS  = 32;

   logic       clk = 1'b0;
   logic       rst_n, tick, en, supply_ok;
   logic [6:0] ref_code;
   logic       drv_en, up_done, down_done;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   softramp_seq u_softramp_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .en        (en),
      .supply_ok (supply_ok),
      .ref_code  (ref_code),
      .drv_en    (drv_en),
      .up_done   (up_done),
      .down_done (down_done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; en = 1'b0; supply_ok = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "code", int'(ref_code), 0);
      chk("R1", "drv_en", int'(drv_en), 0);
      chk("R1", "up_done", int'(up_done), 0);
      chk("R1", "down_done", int'(down_done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: off with enable low, ticks ignored
      supply_ok = 1'b1;
      ticks(40);
      chk("R2", "code idle", int'(ref_code), 0);
      chk("R2", "drv_en idle", int'(drv_en), 0);
      en = 1'b1;
      @(negedge clk);
      chk("R2", "drv_en start", int'(drv_en), 1);
      chk("R2", "code start", int'(ref_code), 0);

      // R3/R4/R5: full upward sweep
      for (int k = 1; k <= FULL; k++) begin
         ticks(TPS - 1);
         chk("R3", "hold before step up", int'(ref_code), k - 1);
         ticks(1);
         chk("R4", "step up", int'(ref_code), k);
         chk("R5", "up_done", int'(up_done), (k == FULL) ? 1 : 0);
      end
      @(negedge clk);
      chk("R5", "up_done width", int'(up_done), 0);
      ticks(100);
      chk("R4", "hold at top", int'(ref_code), FULL);

      // R6/R7: full downward sweep
      en = 1'b0;
      @(negedge clk);
      chk("R6", "drv_en after en low", int'(drv_en), 1);
      for (int k = FULL - 1; k >= 0; k--) begin
         ticks(TPS - 1);
         chk("R3", "hold before step down", int'(ref_code), k + 1);
         chk("R6", "drv_en during ramp", int'(drv_en), 1);
         ticks(1);
         chk("R6", "step down", int'(ref_code), k);
         chk("R7", "drv_en", int'(drv_en), (k == 0) ? 0 : 1);
         chk("R7", "down_done", int'(down_done), (k == 0) ? 1 : 0);
      end
      @(negedge clk);
      chk("R7", "down_done width", int'(down_done), 0);

      // R9/R8: reversals mid-step
      en = 1'b1;
      @(negedge clk);
      ticks(TPS * 10);
      chk("R4", "partial ramp", int'(ref_code), 10);
      ticks(5);
      en = 1'b0;
      @(negedge clk);
      ticks(TPS - 1);
      chk("R9", "no early step", int'(ref_code), 10);
      ticks(1);
      chk("R9", "first step down", int'(ref_code), 9);
      ticks(7);
      en = 1'b1;
      @(negedge clk);
      ticks(TPS - 1);
      chk("R8", "no drop after reverse", int'(ref_code), 9);
      chk("R8", "drv_en after reverse", int'(drv_en), 1);
      ticks(1);
      chk("R8", "first step up", int'(ref_code), 10);

      // R10: undervoltage override
      ticks(3);
      supply_ok = 1'b0;
      @(negedge clk);
      chk("R10", "code", int'(ref_code), 0);
      chk("R10", "drv_en", int'(drv_en), 0);
      chk("R10", "down_done", int'(down_done), 0);
      ticks(50);
      chk("R10", "code with ticks", int'(ref_code), 0);
      chk("R10", "drv_en with ticks", int'(drv_en), 0);

      // R11: recovery with enable high
      supply_ok = 1'b1;
      @(negedge clk);
      chk("R11", "drv_en", int'(drv_en), 1);
      chk("R11", "code", int'(ref_code), 0);
      ticks(TPS - 1);
      chk("R11", "hold", int'(ref_code), 0);
      ticks(1);
      chk("R11", "first step", int'(ref_code), 1);

      // R12: enable drop before first step
      supply_ok = 1'b0;
      @(negedge clk);
      supply_ok = 1'b1;
      @(negedge clk);
      chk("R12", "restart drv_en", int'(drv_en), 1);
      ticks(3);
      en = 1'b0;
      @(negedge clk);
      chk("R12", "drv_en", int'(drv_en), 0);
      chk("R12", "down_done", int'(down_done), 1);
      chk("R12", "code", int'(ref_code), 0);
      @(negedge clk);
      chk("R12", "down_done width", int'(down_done), 0);

      done = 1;
      report();
   end
endmodule